// File: doc/BRIEF.md
# Boundary Scan Test Port Core

This block is the test port of a chip. It has a serial interface with four wires (mode select, test clock, serial in, serial out) and an optional asynchronous test reset. A 16-state controller follows the mode-select input on each rising test clock edge. A 4-bit instruction register picks the serial path that joins the serial input to the serial output. That path is either a one-cell bypass stage or a boundary chain. The boundary chain has one capture cell per input pin, one data cell per output pin and one enable cell per output pin.

The boundary chain has a shift stage and an update stage. The update stage drives the output pin data and the output enables. Output enables reach the pins only while external test is the active instruction. During external test the block also requests a reset of the system logic, so that the system starts from a known state while the pins are under test control. The sample/preload instruction lets the tester load the update stage before external test starts. It also lets the tester take a snapshot of the pins.

Top module: `tap_scan_core`

## Requirements
- R1: The controller reaches Test-Logic-Reset after five rising edges with mode select high, from any state. It also reaches that state at once when the test reset is low. One edge after entering Test-Logic-Reset, and at once under test reset, the active instruction is bypass.
- R2: In Capture-IR the instruction shift stage loads 4'b0001. Shifted out least significant bit first, this gives 1, 0, 0, 0.
- R3: The active instruction changes only on the rising edge that leaves Update-IR, or in Test-Logic-Reset. Shifting and exiting leave it unchanged.
- R4: The codes decode as follows: 4'b0000 is external test, 4'b0001 is sample/preload and 4'b1111 is bypass. Every other code behaves as bypass.
- R5: When the bypass stage is selected, Capture-DR clears it. The first bit shifted out is 0, and after that each serial input bit appears one shift later.
- R6: Under external test or sample/preload, the data path is the boundary chain, N_IN + 2*N_OUT cells long. Bit 0 is nearest the serial output and holds the input cells. The output data cells follow at N_IN upward, and the enable cells at N_IN+N_OUT upward.
- R7: Capture-DR on the boundary chain loads the input pin values into the input cells. It loads the current update-stage data and enables into the output cells.
- R8: Update-DR loads the output data and enable update latches from the shift stage, but only under external test or sample/preload. Under bypass the latches keep their values.
- R9: Output pin data always follows the data update latch. Output enables reach the pins only under external test and are 0 otherwise.
- R10: The system reset request is high exactly while external test is the active instruction.
- R11: The serial output and its enable change on the falling test clock edge. The enable is high only in Shift-IR and Shift-DR, and the serial output is 0 while the enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_en | output | 1 | Serial output enable |
| pin_in | input | N_IN | Input pin values for capture |
| pin_out | output | N_OUT | Output pin data from the update latches |
| pin_oe | output | N_OUT | Output pin enables, active only under external test |
| sys_rst_req | output | 1 | System logic reset request during external test |

## Verification
The hardest case to reach is a capture under external test that must return three sources at once. Those sources are live input pins and two update latches that were written by an earlier sample/preload. The bench reaches it in steps. It first preloads a known data and enable pattern under sample/preload and checks that the enables stay off. It then switches to external test and drives a distinct input pattern. Finally it captures and shifts the whole chain, shifting the same preload pattern back in, so that one full scan shows every cell group in place.

// File: rtl/tap_scan_pkg.sv
package tap_scan_pkg;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 4;
  typedef logic [IR_W-1:0] ir_t;

  localparam ir_t OP_EXTEST  = 4'b0000;
  localparam ir_t OP_SAMPLE  = 4'b0001;
  localparam ir_t OP_BYPASS  = 4'b1111;
  localparam ir_t IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/tap_rst_sync.sv
module tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);
  tap_state_e state_d;

  always_comb begin
    state_d = state;
    unique case (state)
      ST_TLR:    state_d = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: state_d = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  state_d = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: state_d = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: state_d = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: state_d = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: state_d = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: state_d = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  state_d = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: state_d = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: state_d = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: state_d = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: state_d = tms ? ST_SEL_DR : ST_RTI;
      default:   state_d = ST_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= ST_TLR;
    else        state <= state_d;
  end

  // R1: five consecutive high mode-select samples always land in reset state
  assert_five_tms_R1: assert property (@(posedge tck) disable iff (!rst_n)
    ($past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4) && $past(tms, 5))
      |-> (state == ST_TLR));
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import tap_scan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tdi,
  input  tap_state_e state,
  output logic       ir_so,
  output logic       is_extest,
  output logic       bsr_sel
);
  ir_t sh_q, sh_d;
  ir_t ir_q, ir_d;
  logic sh_en, ir_en;

  assign sh_en = (state == ST_CAP_IR) || (state == ST_SH_IR);
  assign ir_en = (state == ST_UPD_IR) || (state == ST_TLR);

  always_comb begin
    sh_d = (state == ST_CAP_IR) ? IR_CAPTURE : {tdi, sh_q[IR_W-1:1]};
    ir_d = (state == ST_TLR) ? OP_BYPASS : sh_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
      ir_q <= OP_BYPASS;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (ir_en) ir_q <= ir_d;
    end
  end

  assign ir_so     = sh_q[0];
  assign is_extest = (ir_q == OP_EXTEST);
  assign bsr_sel   = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPLE);

  // R2: capture loads the fixed pattern
  assert_ir_capture_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_IR) |=> (sh_q == IR_CAPTURE));

  // R3: active instruction only moves after Update-IR or reset state
  assert_ir_hold_R3: assert property (@(posedge tck) disable iff (!rst_n)
    !$stable(ir_q) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR));
endmodule

// File: rtl/tap_bsr.sv
module tap_bsr
  import tap_scan_pkg::*;
#(
  parameter int N_IN  = 159,
  parameter int N_OUT = 158
) (
  input  logic             tck,
  input  logic             rst_n,
  input  logic             tdi,
  input  tap_state_e       state,
  input  logic             bsr_sel,
  input  logic [N_IN-1:0]  pin_in,
  output logic             bsr_so,
  output logic [N_OUT-1:0] out_q,
  output logic [N_OUT-1:0] oe_q
);
  localparam int LEN     = N_IN + 2 * N_OUT;
  localparam int OUT_LSB = N_IN;
  localparam int OE_LSB  = N_IN + N_OUT;

  logic [LEN-1:0] sh_q, sh_d, cap_vec;
  logic sh_en, upd_en;

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_out_cell
      assign cap_vec[OUT_LSB + gi] = out_q[gi];
      assign cap_vec[OE_LSB + gi]  = oe_q[gi];
    end
  endgenerate
  assign cap_vec[N_IN-1:0] = pin_in;

  assign sh_en  = bsr_sel && ((state == ST_CAP_DR) || (state == ST_SH_DR));
  assign upd_en = bsr_sel && (state == ST_UPD_DR);

  always_comb begin
    sh_d = (state == ST_CAP_DR) ? cap_vec : {tdi, sh_q[LEN-1:1]};
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      if (sh_en) sh_q <= sh_d;
      if (upd_en) begin
        out_q <= sh_q[OUT_LSB +: N_OUT];
        oe_q  <= sh_q[OE_LSB +: N_OUT];
      end
    end
  end

  assign bsr_so = sh_q[0];

  // R7: capture takes the live input pins
  assert_bsr_capture_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && bsr_sel) |=> (sh_q[N_IN-1:0] == $past(pin_in)));

  // R8: update latches move only on Update-DR with the chain selected
  assert_upd_only_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (!$stable(out_q) || !$stable(oe_q)) |-> ($past(state) == ST_UPD_DR && $past(bsr_sel)));
endmodule

// File: rtl/tap_scan_core.sv
module tap_scan_core
  import tap_scan_pkg::*;
#(
  parameter int N_IN  = 159,
  parameter int N_OUT = 158
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_en,
  input  logic [N_IN-1:0]  pin_in,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe,
  output logic             sys_rst_req
);
  logic       rst_n;
  tap_state_e state;
  logic       ir_so, is_extest, bsr_sel, bsr_so;
  logic [N_OUT-1:0] out_q, oe_q;
  logic       byp_q, byp_d, byp_en;
  logic       tdo_d, tdo_en_d;

  tap_rst_sync #(.STAGES(2)) u_rst (.clk(tck), .arst_n(trst_n), .rst_n(rst_n));

  tap_fsm u_fsm (.tck(tck), .rst_n(rst_n), .tms(tms), .state(state));

  tap_ir u_ir (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state),
    .ir_so(ir_so), .is_extest(is_extest), .bsr_sel(bsr_sel)
  );

  tap_bsr #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr (
    .tck(tck), .rst_n(rst_n), .tdi(tdi), .state(state), .bsr_sel(bsr_sel),
    .pin_in(pin_in), .bsr_so(bsr_so), .out_q(out_q), .oe_q(oe_q)
  );

  // single-cell bypass stage
  assign byp_en = !bsr_sel && ((state == ST_CAP_DR) || (state == ST_SH_DR));
  assign byp_d  = (state == ST_SH_DR) ? tdi : 1'b0;

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)      byp_q <= 1'b0;
    else if (byp_en) byp_q <= byp_d;
  end

  // serial output, retimed to the falling edge
  always_comb begin
    tdo_en_d = (state == ST_SH_IR) || (state == ST_SH_DR);
    tdo_d    = 1'b0;
    if (state == ST_SH_IR)      tdo_d = ir_so;
    else if (state == ST_SH_DR) tdo_d = bsr_sel ? bsr_so : byp_q;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= tdo_d;
      tdo_en <= tdo_en_d;
    end
  end

  assign pin_out     = out_q;
  assign pin_oe      = is_extest ? oe_q : '0;
  assign sys_rst_req = is_extest;

  // R5: bypass stage reads zero after capture
  assert_bypass_zero_R5: assert property (@(posedge tck) disable iff (!rst_n)
    (state == ST_CAP_DR && !bsr_sel) |=> !byp_q);

  // R9: enables at the pins only alongside the system reset request
  assert_oe_gate_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (|pin_oe) |-> sys_rst_req);

  // R10: external test always routes through the boundary chain
  assert_extest_path_R10: assert property (@(posedge tck) disable iff (!rst_n)
    sys_rst_req |-> bsr_sel);

  // R11: serial output quiet while not enabled
  assert_tdo_quiet_R11: assert property (@(posedge tck) disable iff (!rst_n)
    !tdo_en |-> !tdo);
endmodule

// File: tb/tap_scan_core_bench.sv
module tap_scan_core_bench;
  localparam int N_IN  = 4;
  localparam int N_OUT = 3;
  localparam int LEN   = N_IN + 2 * N_OUT;

  // {code[3:0], expect system reset, expect boundary chain}
  localparam logic [5:0] VEC [6] = '{
    {4'b0000, 1'b1, 1'b1},
    {4'b0001, 1'b0, 1'b1},
    {4'b1111, 1'b0, 1'b0},
    {4'b0101, 1'b0, 1'b0},
    {4'b1000, 1'b0, 1'b0},
    {4'b0111, 1'b0, 1'b0}
  };

  logic tck, trst_n, tms, tdi, tdo, tdo_en, sys_rst_req;
  logic [N_IN-1:0]  pin_in;
  logic [N_OUT-1:0] pin_out, pin_oe;
  int n_chk, n_fail;
  logic tdo_s;

  tap_scan_core #(.N_IN(N_IN), .N_OUT(N_OUT)) u_tap_scan_core (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .sys_rst_req(sys_rst_req)
  );

  initial tck = 1'b0;
  always #4 tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tms_v, input logic tdi_v);
    @(negedge tck); #1;
    tdo_s = tdo;
    tms = tms_v;
    tdi = tdi_v;
    @(posedge tck); #1;
  endtask

  task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      step(i == 3, code[i]);
      cap[i] = tdo_s;
    end
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] vin, output logic [63:0] vout);
    vout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, vin[i]);
      vout[i] = tdo_s;
    end
    step(1, 0); step(0, 0);
  endtask

  initial begin
    #(64'd8 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0]  cap;
    logic [63:0] vout, pat;
    n_chk = 0; n_fail = 0;
    trst_n = 0; tms = 1; tdi = 0; pin_in = '0; tdo_s = 0;
    repeat (3) @(posedge tck);
    #1;
    chk("R11 reset tdo_en", 64'(tdo_en), 64'd0);
    chk("R11 reset tdo", 64'(tdo), 64'd0);
    chk("R10 reset sys_rst_req", 64'(sys_rst_req), 64'd0);
    chk("R9 reset pin_oe", 64'(pin_oe), 64'd0);
    trst_n = 1;
    repeat (4) step(1, 0);
    step(0, 0);

    // instruction table: decode, capture pattern, path length
    for (int k = 0; k < 6; k++) begin
      load_ir(VEC[k][5:2], cap);
      chk("R2 IR capture pattern", 64'(cap), 64'h1);
      chk("R10 R4 system reset per code", 64'(sys_rst_req), 64'(VEC[k][1]));
      scan_dr(LEN + 1, 64'h1, vout);
      chk("R4 R5 R6 path length", vout & ((64'd1 << (LEN + 1)) - 1),
          64'd1 << (VEC[k][0] ? LEN : 1));
    end

    // preload under sample: enables 110, data 101
    pat = 64'({3'b110, 3'b101, 4'b0000});
    load_ir(4'b0001, cap);
    scan_dr(LEN, pat, vout);
    chk("R8 preload pin_out", 64'(pin_out), 64'b101);
    chk("R9 no enables under sample", 64'(pin_oe), 64'd0);
    load_ir(4'b0000, cap);
    chk("R9 enables under extest", 64'(pin_oe), 64'b110);
    chk("R10 extest reset request", 64'(sys_rst_req), 64'd1);

    // R3: instruction held through shift and exit
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(i == 3, 1'b1);
    chk("R3 held in Exit1-IR", 64'(sys_rst_req), 64'd1);
    step(1, 0);
    chk("R3 held in Update-IR", 64'(sys_rst_req), 64'd1);
    step(0, 0);
    chk("R3 changed after Update-IR", 64'(sys_rst_req), 64'd0);

    // R7: full capture under extest
    load_ir(4'b0000, cap);
    pin_in = 4'b1011;
    scan_dr(LEN, pat, vout);
    chk("R7 capture pins and latches", vout & ((64'd1 << LEN) - 1),
        64'({3'b110, 3'b101, 4'b1011}));

    // R8: bypass scan leaves latches
    load_ir(4'b1111, cap);
    scan_dr(2, 64'h3, vout);
    chk("R8 pin_out kept under bypass", 64'(pin_out), 64'b101);
    load_ir(4'b0000, cap);
    chk("R8 enable latch kept under bypass", 64'(pin_oe), 64'b110);

    // R11: serial output moves on falling edge
    load_ir(4'b1111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    @(negedge tck); #1;
    chk("R11 tdo_en in Shift-DR", 64'(tdo_en), 64'd1);
    chk("R5 first bypass bit", 64'(tdo), 64'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R11 tdo stable after rising edge", 64'(tdo), 64'd0);
    @(negedge tck); #1;
    chk("R11 tdo updates on falling edge", 64'(tdo), 64'd1);
    tms = 1; tdi = 0;
    @(posedge tck); #1;
    step(1, 0); step(0, 0);
    chk("R11 tdo_en off in idle", 64'(tdo_en), 64'd0);

    // R1: five high mode-select edges from Shift-DR
    load_ir(4'b0000, cap);
    step(1, 0); step(0, 0); step(0, 0);
    repeat (6) step(1, 0);
    chk("R1 TMS reset restores bypass", 64'(sys_rst_req), 64'd0);
    step(0, 0);

    // R1: asynchronous test reset
    load_ir(4'b0000, cap);
    chk("R1 extest before trst", 64'(sys_rst_req), 64'd1);
    #2 trst_n = 0;
    #1;
    chk("R1 trst clears instruction", 64'(sys_rst_req), 64'd0);
    chk("R9 trst removes enables", 64'(pin_oe), 64'd0);
    tms = 1;
    repeat (2) @(posedge tck);
    trst_n = 1;
    repeat (3) step(1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule